// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block divides a fast clock by a programmable integer ratio and, using a small modular accumulator, stretches some divide cycles by one clock. Over a full accumulator period the average ratio is the integer ratio plus a fraction whose numerator is programmable and whose denominator is 5 or 8. It sits in the feedback path of a frequency synthesizer loop. It sends one pulse per completed divide cycle to the phase comparator. It also exposes the accumulator value so that the phase ripple caused by the stretched cycles can be compensated.

Software-side writes land in staging registers. The staged integer ratio, numerator and modulus select are taken up only on the terminal count of the running divide cycle, so a setting change never shortens or splits a cycle already in progress. A synchronous active-low reset clears the accumulator and restarts the count from the staged settings. A write presented while reset is held is captured, and it governs the first cycle after release.

Top module: `fracn_div_ctrl`

## Requirements
- R1: The staged integer ratio N takes any value from N_MIN up to 2^INT_W-1. A written value below N_MIN is stored as N_MIN.
- R2: `div_pulse` is high for exactly one clock at the terminal count of every divide cycle. A cycle lasts N clocks, or N+1 clocks when stretched.
- R3: At each terminal count the accumulator (`acc_out`) gains the numerator NF, modulo Q. Q is 8 when the mode bit `wr_mod8` was written as 1, and 5 when it was written as 0.
- R4: When the addition at a terminal count reaches or exceeds Q, the cycle that follows is N+1 clocks long. Over any Q consecutive cycles with unchanged settings, the total is Q*N+NF clocks.
- R5: A written NF of Q or above, with Q taken from the mode bit of the same write, is stored as Q-1.
- R6: A write changes only the staged settings. The cycle running at the time keeps its length, and the new settings govern the cycle that begins after the next terminal count.
- R7: `acc_out` changes only on the clock edge that ends a divide cycle.
- R8: While `rst_n` is low at a clock edge, the accumulator is cleared to 0 and the counter reloads from the staged N. After release, the first pulse appears N-1 clock edges after the first edge with `rst_n` high, and it ends a cycle of N clocks.
- R9: When the staged modulus differs from the active one at a terminal count, accumulation restarts from 0. The accumulator then holds NF after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_int | input | INT_W | Integer ratio N to stage |
| wr_num | input | 3 | Fractional numerator NF to stage |
| wr_mod8 | input | 1 | Modulus select to stage: 1 gives Q=8, 0 gives Q=5 |
| div_pulse | output | 1 | One-clock pulse at the end of each divide cycle |
| acc_out | output | 3 | Current fractional accumulator value |

## Verification
The bench builds the block with INT_W=16 and N_MIN lowered to 4. The lower floor makes short ratios legal, so floor clamping, stretched cycles and whole accumulator periods in both moduli fit in a few dozen clocks each. Keeping INT_W at 16 still allows a run with a 600-clock ratio and one full 65535-clock cycle, which checks the upper end of the counter width. A behavioural model, compared on every clock, follows mid-cycle writes, modulus switches, numerator clamping and a reset in mid-run.

// File: rtl/fracn_pkg.sv
// fracn_pkg: constants and helpers shared by the fractional-N divider.
// Assumes a 3-bit numerator, which covers both moduli (5 and 8).
package fracn_pkg;

    localparam int FRAC_W  = 3;
    localparam int Q_SMALL = 5;
    localparam int Q_LARGE = 8;

    // Modulus selected by the mode bit.
    function automatic logic [FRAC_W:0] mod_q(input logic m8);
        return m8 ? (FRAC_W+1)'(Q_LARGE) : (FRAC_W+1)'(Q_SMALL);
    endfunction

    // Limits a numerator to Q-1 for the given mode.
    function automatic logic [FRAC_W-1:0] clamp_nf(input logic [FRAC_W-1:0] nf,
                                                  input logic m8);
        logic [FRAC_W:0] q;
        q = mod_q(m8);
        if ({1'b0, nf} >= q)
            return FRAC_W'(q - 1'b1);
        return nf;
    endfunction

endpackage

// File: rtl/fracn_shadow.sv
// fracn_shadow: staging registers for ratio, numerator and mode, plus the
// active copy of the mode bit.
// Assumes settings are written at least once before or during the first reset.
// Staged values are clamped on entry. The active mode follows the staged one
// only on a terminal count or while reset is held.
module fracn_shadow
    import fracn_pkg::*;
#(
    parameter int INT_W = 16,
    parameter int N_MIN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc,
    input  logic              wr_en,
    input  logic [INT_W-1:0]  wr_int,
    input  logic [FRAC_W-1:0] wr_num,
    input  logic              wr_mod8,
    output logic [INT_W-1:0]  stage_n,
    output logic [FRAC_W-1:0] stage_nf,
    output logic              stage_m8,
    output logic              act_m8
);

    localparam logic [INT_W-1:0] N_FLOOR = INT_W'(N_MIN);

    // Capture a write into staging, clamped to the legal ranges.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            stage_n  <= (wr_int < N_FLOOR) ? N_FLOOR : wr_int;
            stage_nf <= clamp_nf(wr_num, wr_mod8);
            stage_m8 <= wr_mod8;
        end
    end

    // Take up the staged mode at a cycle boundary or while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n || tc)
            act_m8 <= stage_m8;
    end

    a_r1_n_floor: assert property (@(posedge clk) disable iff (!rst_n)
        stage_n >= N_FLOOR);

    a_r5_nf_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, stage_nf} < mod_q(stage_m8));

    a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(act_m8));

endmodule

// File: rtl/fracn_accum.sv
// fracn_accum: modulo-Q fractional accumulator.
// Updates only on a terminal count. It adds the staged numerator using the
// staged modulus, and it flags overflow so the coming cycle is stretched.
// Assumes the staged numerator is already below the staged modulus.
module fracn_accum
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc,
    input  logic [FRAC_W-1:0] nf_next,
    input  logic              m8_next,
    input  logic              m8_cur,
    output logic [FRAC_W-1:0] acc,
    output logic              ovf
);

    logic [FRAC_W:0]   q_next;
    logic [FRAC_W:0]   base;
    logic [FRAC_W:0]   sum;
    logic [FRAC_W-1:0] acc_nx;

    // Next value and overflow flag for the coming terminal count.
    always_comb begin
        q_next = mod_q(m8_next);
        base   = (m8_next != m8_cur) ? '0 : {1'b0, acc};
        sum    = base + {1'b0, nf_next};
        ovf    = (sum >= q_next);
        acc_nx = ovf ? FRAC_W'(sum - q_next) : FRAC_W'(sum);
    end

    // Hold the accumulator between terminal counts; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (tc)
            acc <= acc_nx;
    end

    a_r3_acc_below_q: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, acc} < mod_q(m8_cur));

    a_r7_acc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(acc));

endmodule

// File: rtl/fracn_count.sv
// fracn_count: down counter that marks the last clock of each divide cycle.
// Loads init_m1 while reset is held and reload_m1 at the terminal count, so a
// cycle lasts the loaded value plus one clocks.
// Assumes both load values are at least 1, which holds for ratios of 2 or more.
module fracn_count #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] init_m1,
    input  logic [INT_W-1:0] reload_m1,
    output logic             tc
);

    logic [INT_W-1:0] cnt;

    assign tc = (cnt == '0);

    // Count down, reloading at the end of each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= init_m1;
        else if (tc)
            cnt <= reload_m1;
        else
            cnt <= cnt - 1'b1;
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

endmodule

// File: rtl/fracn_div_ctrl.sv
// fracn_div_ctrl: fractional-N main divider controller (top level).
// Divides clk by N or N+1, choosing N+1 after an accumulator overflow. It
// emits a one-clock pulse per cycle and exposes the accumulator value.
// Assumes N_MIN >= 2 and that settings are written before or during reset.
module fracn_div_ctrl
    import fracn_pkg::*;
#(
    parameter int INT_W = 16,
    parameter int N_MIN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [INT_W-1:0]  wr_int,
    input  logic [FRAC_W-1:0] wr_num,
    input  logic              wr_mod8,
    output logic              div_pulse,
    output logic [FRAC_W-1:0] acc_out
);

    logic              tc;
    logic              ovf;
    logic [INT_W-1:0]  stage_n;
    logic [FRAC_W-1:0] stage_nf;
    logic              stage_m8;
    logic              act_m8;
    logic [INT_W-1:0]  init_m1;
    logic [INT_W-1:0]  reload_m1;

    fracn_shadow #(.INT_W(INT_W), .N_MIN(N_MIN)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc       (tc),
        .wr_en    (wr_en),
        .wr_int   (wr_int),
        .wr_num   (wr_num),
        .wr_mod8  (wr_mod8),
        .stage_n  (stage_n),
        .stage_nf (stage_nf),
        .stage_m8 (stage_m8),
        .act_m8   (act_m8)
    );

    fracn_accum u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .tc      (tc),
        .nf_next (stage_nf),
        .m8_next (stage_m8),
        .m8_cur  (act_m8),
        .acc     (acc_out),
        .ovf     (ovf)
    );

    // Cycle length minus one: N-1 normally, N when the cycle is stretched.
    always_comb begin
        init_m1   = stage_n - 1'b1;
        reload_m1 = ovf ? stage_n : init_m1;
    end

    fracn_count #(.INT_W(INT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_m1   (init_m1),
        .reload_m1 (reload_m1),
        .tc        (tc)
    );

    assign div_pulse = tc;

endmodule

// File: tb/sim_fracn_div_ctrl.sv
`timescale 1ns/1ps
module sim_fracn_div_ctrl;

    localparam int INT_W = 16;
    localparam int N_MIN = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [INT_W-1:0] wr_int = '0;
    logic [2:0]       wr_num = '0;
    logic             wr_mod8 = 1'b0;
    logic             div_pulse;
    logic [2:0]       acc_out;

    always #2.5 clk = ~clk;

    fracn_div_ctrl #(.INT_W(INT_W), .N_MIN(N_MIN)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_int(wr_int),
        .wr_num(wr_num), .wr_mod8(wr_mod8),
        .div_pulse(div_pulse), .acc_out(acc_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    // Behavioural model state.
    int st_n = 6, st_nf = 2, st_m8 = 0, md_m8 = 0;
    int m_acc = 0, m_per = 6, m_el = 0;
    int m_base, m_sum, m_q;

    function automatic int fix_n(int v);
        return (v < N_MIN) ? N_MIN : v;
    endfunction

    function automatic int fix_nf(int v, int m8);
        int q = m8 ? 8 : 5;
        return (v > q - 1) ? q - 1 : v;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Model: terminal count uses the old staged settings, then the write is taken.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            md_m8 = st_m8; m_acc = 0; m_per = st_n; m_el = 0;
        end else if (m_el == m_per - 1) begin
            m_base = (st_m8 != md_m8) ? 0 : m_acc;
            md_m8  = st_m8;
            m_q    = st_m8 ? 8 : 5;
            m_sum  = m_base + st_nf;
            if (m_sum >= m_q) begin
                m_acc = m_sum - m_q; m_per = st_n + 1;
            end else begin
                m_acc = m_sum; m_per = st_n;
            end
            m_el = 0;
        end else begin
            m_el++;
        end
        if (wr_en) begin
            st_n  = fix_n(int'(wr_int));
            st_m8 = int'(wr_mod8);
            st_nf = fix_nf(int'(wr_num), int'(wr_mod8));
        end
        if (cyc > 195000) begin
            errors++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 195000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(div_pulse == (m_el == m_per - 1), "R2 pulse",
                  int'(div_pulse), int'(m_el == m_per - 1));
            check(int'(acc_out) == m_acc, "R3 acc", int'(acc_out), m_acc);
        end
    end

    task automatic wr(int n, int nf, int m8);
        @(negedge clk);
        wr_int = INT_W'(n); wr_num = 3'(nf); wr_mod8 = m8[0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_pulse(output int t);
        do @(negedge clk); while (!div_pulse);
        t = cyc;
    endtask

    task automatic span(int k, output int d);
        int t0, t;
        next_pulse(t0);
        t = t0;
        repeat (k) next_pulse(t);
        d = t - t0;
    endtask

    initial begin
        int t0, t1, t2, d, a;
        // Write presented during reset, from time zero (R8).
        wr_int = 16'd6; wr_num = 3'd2; wr_mod8 = 1'b0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check(acc_out == 3'd0, "R8 reset acc", int'(acc_out), 0);
        check(div_pulse == 1'b0, "R8 reset pulse", int'(div_pulse), 0);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        t0 = cyc;
        next_pulse(t1);
        check(t1 - t0 == 5, "R8 first pulse", t1 - t0, 5);
        @(negedge clk);
        check(div_pulse == 1'b0, "R2 one clock wide", int'(div_pulse), 0);

        // Q=5, N=6, NF=2: five cycles take 32 clocks (R4).
        span(5, d);
        check(d == 32, "R4 average mod5", d, 32);

        // Switch to Q=8 with N=7, NF=3 (R9, R3).
        wr(7, 3, 1);
        next_pulse(t0);
        @(negedge clk);
        check(acc_out == 3'd3, "R9 restart from zero", int'(acc_out), 3);
        span(8, d);
        check(d == 59, "R3 average mod8", d, 59);

        // Numerator 7 in Q=5 is clamped to 4 (R5).
        wr(6, 7, 0);
        next_pulse(t0);
        @(negedge clk);
        check(acc_out == 3'd4, "R5 clamped numerator", int'(acc_out), 4);
        span(5, d);
        check(d == 34, "R5 average with clamp", d, 34);

        // Ratio below the floor is stored as N_MIN (R1).
        wr(1, 0, 0);
        span(3, d);
        check(d == 12, "R1 floor clamp", d, 12);

        // Mid-cycle write leaves the running cycle alone (R6).
        next_pulse(t0);
        wr(9, 0, 0);
        next_pulse(t1);
        check(t1 - t0 == 4, "R6 running cycle kept", t1 - t0, 4);
        next_pulse(t2);
        check(t2 - t1 == 9, "R6 new ratio after boundary", t2 - t1, 9);

        // Accumulator holds inside a cycle (R7).
        wr(10, 3, 0);
        next_pulse(t0);
        next_pulse(t0);
        @(negedge clk);
        a = int'(acc_out);
        repeat (6) begin
            @(negedge clk);
            check(int'(acc_out) == a, "R7 acc held mid-cycle", int'(acc_out), a);
        end

        // Reset in mid-run (R8).
        next_pulse(t0);
        next_pulse(t0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(acc_out == 3'd0, "R8 mid-run reset acc", int'(acc_out), 0);
        rst_n = 1'b1;
        t0 = cyc;
        next_pulse(t1);
        check(t1 - t0 == 9, "R8 restart length", t1 - t0, 9);

        // Larger ratios up to the top of the counter width (R1, R4).
        wr(600, 1, 0);
        span(5, d);
        check(d == 3001, "R4 average N=600", d, 3001);
        wr(65535, 0, 0);
        span(1, d);
        check(d == 65535, "R1 maximum ratio", d, 65535);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule